// File: doc/BRIEF.md
# Interrupt Output Controller with Holdoff

This block merges a vector of pending interrupt sources into one master interrupt and drives a single external request pin. Each source bit arrives already qualified by its own enable. After every delivered assertion ends, the block can hold off further deliveries for a programmable quiet period. The period is an 8-bit count of 10 microsecond ticks. An internal prescaler derives the tick from the core clock frequency, which is fixed at elaboration. A power-management request bypasses the quiet period.

Software controls the block through one configuration word, written with a single-cycle strobe. The word holds the quiet-period length, a self-clearing restart bit, the pin enable, the output polarity and the buffer type. A read of the same word also returns two live status bits: whether a quiet period is running, and the master interrupt. The pin is driven as a data value plus an output enable. Open-drain behaviour is emulated by driving low through the enable.

Write-word layout: bits [7:0] interval length, bit 8 restart, bit 9 pin enable, bit 10 polarity, bit 11 buffer type (1 = push-pull). Read-word layout: bits [11:0] mirror the stored configuration, with bit 8 always reading 0. Bit 12 is the holdoff status and bit 13 is the master interrupt.

Top module: `irq_out_ctrl`

## Requirements
- R1: Read bit 13 (master) equals the OR of `src_pending` in the same cycle, whatever the pin enable and the holdoff state.
- R2: While the pin enable (bit 9) is 0, the pin is never asserted, not even by `pme_irq`, while bit 13 still follows the sources.
- R3: With push-pull (bit 11 = 1), `irq_oe` is 1. `irq_out` is high when asserted for polarity 1 and low when asserted for polarity 0. An asserted state appears one clock edge after the sources rise.
- R4: With open-drain (bit 11 = 0), `irq_out` is always 0 and `irq_oe` is 1 exactly when asserted, whatever the polarity bit.
- R5: When a delivered source assertion goes inactive and the interval field is non-zero, a quiet period starts on that clock edge. Read bit 12 is then 1 for exactly interval × 500 cycles with the default 50 MHz clock.
- R6: During a quiet period, pending sources do not reach the pin. A source still pending is asserted on the first clock edge after bit 12 reads 0.
- R7: Writing interval 0 ends any quiet period on that write edge, and a pending source is asserted on the following edge. With interval 0, no quiet period starts.
- R8: Writing a new non-zero interval while a quiet period runs leaves that period's length unchanged. The new value governs later periods.
- R9: Writing 1 to the restart bit with a non-zero interval starts a full new quiet period from the write edge, whether or not one is running. The bit reads back 0.
- R10: With the pin enabled, `pme_irq` asserts the pin one edge later, even during a quiet period.
- R11: After reset, the read word is all zero and the pin is deasserted as open-drain (`irq_out` = 0, `irq_oe` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 12 | Configuration write word |
| cfg_rdata | output | 14 | Configuration and status read word |
| src_pending | input | N_SRC | Enabled, pending interrupt sources |
| pme_irq | input | 1 | Power-management interrupt request |
| irq_out | output | 1 | Pin data value |
| irq_oe | output | 1 | Pin output enable |

## Verification
The bench measures quiet-period lengths cycle by cycle. A prescaler that is off by one, or a counter that stops one tick early, shows up as an exact length mismatch. It rewrites the interval in the middle of a period: a design that reloads its counter on any write stretches that period to the new length. It also restarts a period in the middle of a run and from idle. A restart that ignores the prescaler phase, or that works only when a period is running, gives a wrong length. Finally, it cancels a period with a zero interval, raises `pme_irq` inside a period, and checks polarity against buffer type. A design that let the holdoff gate the power-management path, or that honoured polarity in open-drain mode, would drive the wrong pin level.

// File: rtl/irq_out_pkg.sv
package irq_out_pkg;
    localparam int IVL_W = 8;

    localparam int WB_RESTART = 8;
    localparam int WB_EN      = 9;
    localparam int WB_POL     = 10;
    localparam int WB_PP      = 11;
    localparam int WR_W       = 12;
    localparam int RB_HOLD    = 12;
    localparam int RB_MASTER  = 13;
    localparam int RD_W       = 14;

    typedef struct packed {
        logic [IVL_W-1:0] ivl;
        logic             en;
        logic             pol;
        logic             pp;
    } cfg_t;
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
    parameter int CLK_HZ  = 50_000_000,
    parameter int TICK_HZ = 100_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int DIV = (CLK_HZ / TICK_HZ < 1) ? 1 : CLK_HZ / TICK_HZ;
    localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = 1'b0;
        if (clr) begin
            s_d.cnt = '0;
        end else if (run) begin
            if (s_q.cnt == LAST) begin
                s_d.cnt = '0;
                tick    = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/irq_holdoff.sv
module irq_holdoff #(
    parameter int IVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             restart,
    input  logic             cancel,
    input  logic [IVL_W-1:0] len,
    output logic             active,
    output logic             presc_clr
);
    typedef struct packed {
        logic             active;
        logic [IVL_W-1:0] remain;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.active && tick) begin
            if (s_q.remain <= IVL_W'(1)) begin
                s_d.active = 1'b0;
                s_d.remain = '0;
            end else begin
                s_d.remain = s_q.remain - 1'b1;
            end
        end
        if (start || restart) begin
            s_d.active = 1'b1;
            s_d.remain = len;
        end
        if (cancel) begin
            s_d.active = 1'b0;
            s_d.remain = '0;
        end
        presc_clr = start | restart | cancel | ~s_q.active;
    end

    assign active = s_q.active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic master,
    input  logic hold,
    input  logic pme,
    input  logic pol,
    input  logic pp,
    output logic irq_out,
    output logic irq_oe,
    output logic del_fall
);
    typedef struct packed {
        logic del;
        logic pme_on;
    } st_t;

    st_t  s_d, s_q;
    logic on;

    always_comb begin
        s_d.del    = en & master & ~hold;
        s_d.pme_on = en & pme;
        del_fall   = s_q.del & ~s_d.del;
        on         = s_q.del | s_q.pme_on;
        if (pp) begin
            irq_oe  = 1'b1;
            irq_out = pol ? on : ~on;
        end else begin
            irq_oe  = on;
            irq_out = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/irq_out_ctrl.sv
module irq_out_ctrl
    import irq_out_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int CLK_HZ = 50_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [WR_W-1:0]  cfg_wdata,
    output logic [RD_W-1:0]  cfg_rdata,
    input  logic [N_SRC-1:0] src_pending,
    input  logic             pme_irq,
    output logic             irq_out,
    output logic             irq_oe
);
    cfg_t cfg_d, cfg_q;
    logic master, hold, presc_clr, tick, del_fall;
    logic start, restart, cancel;

    always_comb begin
        cfg_d   = cfg_q;
        restart = 1'b0;
        cancel  = 1'b0;
        if (cfg_we) begin
            cfg_d.ivl = cfg_wdata[IVL_W-1:0];
            cfg_d.en  = cfg_wdata[WB_EN];
            cfg_d.pol = cfg_wdata[WB_POL];
            cfg_d.pp  = cfg_wdata[WB_PP];
            cancel    = (cfg_wdata[IVL_W-1:0] == '0);
            restart   = cfg_wdata[WB_RESTART] & ~cancel;
        end
        master = |src_pending;
        start  = del_fall & (cfg_d.ivl != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    irq_tick_gen #(.CLK_HZ(CLK_HZ), .TICK_HZ(100_000)) i_tick (
        .clk(clk), .rst_n(rst_n), .clr(presc_clr), .run(hold), .tick(tick)
    );

    irq_holdoff #(.IVL_W(IVL_W)) i_hold (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
        .restart(restart), .cancel(cancel), .len(cfg_d.ivl),
        .active(hold), .presc_clr(presc_clr)
    );

    irq_pin_drv i_pin (
        .clk(clk), .rst_n(rst_n), .en(cfg_d.en), .master(master),
        .hold(hold), .pme(pme_irq), .pol(cfg_q.pol), .pp(cfg_q.pp),
        .irq_out(irq_out), .irq_oe(irq_oe), .del_fall(del_fall)
    );

    assign cfg_rdata = {master, hold, cfg_q.pp, cfg_q.pol, cfg_q.en,
                        1'b0, cfg_q.ivl};
endmodule

// File: rtl/irq_out_ctrl_chk.sv
module irq_out_ctrl_chk #(
    parameter int N_SRC = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             en,
    input logic             pol,
    input logic             pp,
    input logic             hold,
    input logic             master,
    input logic [N_SRC-1:0] src_pending,
    input logic             pme_irq,
    input logic             irq_out,
    input logic             irq_oe
);
    logic on;
    assign on = pp ? (irq_out == pol) : irq_oe;

    // R1
    master_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        master == (|src_pending));

    // R2
    pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !on);

    // R3
    pp_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pp |-> irq_oe);

    // R4
    od_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pp |-> !irq_out);

    // R6
    hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !pme_irq) |=> !on);

    // R10
    pme_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pme_irq && en && !cfg_we) |=> on);
endmodule

bind irq_out_ctrl irq_out_ctrl_chk #(.N_SRC(N_SRC)) i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .en(cfg_rdata[9]), .pol(cfg_rdata[10]), .pp(cfg_rdata[11]),
    .hold(cfg_rdata[12]), .master(cfg_rdata[13]),
    .src_pending(src_pending), .pme_irq(pme_irq),
    .irq_out(irq_out), .irq_oe(irq_oe)
);

// File: tb/test_irq_out_ctrl.sv
`timescale 1ns/1ps
module test_irq_out_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_wdata = '0;
    logic [13:0] cfg_rdata;
    logic [7:0]  src_pending = '0;
    logic        pme_irq = 1'b0;
    logic        irq_out, irq_oe;
    int          n_chk = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    irq_out_ctrl i_irq_out_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .src_pending(src_pending), .pme_irq(pme_irq),
        .irq_out(irq_out), .irq_oe(irq_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int ivl, input bit rs, input bit en, input bit pol, input bit pp);
        cfg_wdata = {pp, pol, en, rs, 8'(ivl)};
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic hold_len(output int n);
        n = 0;
        while (cfg_rdata[12]) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_src();
        src_pending = 8'h01;
        @(negedge clk);
        src_pending = 8'h00;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(cfg_rdata == 14'd0, "R11 rdata", cfg_rdata, 0);
        chk(irq_out == 1'b0 && irq_oe == 1'b0, "R11 pin", {irq_out, irq_oe}, 0);
    endtask

    task automatic t_master();
        wr(0, 0, 0, 1, 1);
        src_pending = 8'h40; #1;
        chk(cfg_rdata[13] == 1'b1, "R1 one bit", cfg_rdata[13], 1);
        src_pending = 8'hff; #1;
        chk(cfg_rdata[13] == 1'b1, "R1 all bits", cfg_rdata[13], 1);
        @(negedge clk);
        chk(irq_out == 1'b0, "R2 disabled pin", irq_out, 0);
        src_pending = 8'h00; #1;
        chk(cfg_rdata[13] == 1'b0, "R1 none", cfg_rdata[13], 0);
        @(negedge clk);
    endtask

    task automatic t_polarity();
        int n;
        wr(2, 0, 1, 1, 1);
        src_pending = 8'h01;
        @(negedge clk);
        chk(irq_out == 1'b1 && irq_oe == 1'b1, "R3 active high", irq_out, 1);
        wr(2, 0, 1, 0, 1);
        chk(irq_out == 1'b0, "R3 active low", irq_out, 0);
        wr(2, 0, 1, 1, 1);
        src_pending = 8'h00;
        @(negedge clk);
        chk(cfg_rdata[12] == 1'b1, "R5 start", cfg_rdata[12], 1);
        hold_len(n);
        chk(n == 1000, "R5 length", n, 1000);
        chk(irq_out == 1'b0, "R5 pin idle", irq_out, 0);
    endtask

    task automatic t_block();
        int n;
        pulse_src();
        src_pending = 8'h10;
        repeat (50) @(negedge clk);
        chk(irq_out == 1'b0, "R6 blocked", irq_out, 0);
        hold_len(n);
        chk(irq_out == 1'b0, "R6 edge after end", irq_out, 0);
        @(negedge clk);
        chk(irq_out == 1'b1, "R6 delivered", irq_out, 1);
        wr(0, 0, 1, 1, 1);
        src_pending = 8'h00;
        @(negedge clk);
        @(negedge clk);
        chk(cfg_rdata[12] == 1'b0, "R7 no period at zero", cfg_rdata[12], 0);
    endtask

    task automatic t_cancel();
        wr(3, 0, 1, 1, 1);
        pulse_src();
        src_pending = 8'h02;
        repeat (20) @(negedge clk);
        wr(0, 0, 1, 1, 1);
        chk(cfg_rdata[12] == 1'b0, "R7 cancelled", cfg_rdata[12], 0);
        @(negedge clk);
        chk(irq_out == 1'b1, "R7 pending sent", irq_out, 1);
        src_pending = 8'h00;
        @(negedge clk);
        chk(cfg_rdata[12] == 1'b0, "R7 idle", cfg_rdata[12], 0);
    endtask

    task automatic t_rewrite();
        int n;
        wr(2, 0, 1, 1, 1);
        pulse_src();
        n = 0;
        while (cfg_rdata[12]) begin
            if (n == 100) begin
                cfg_wdata = 12'hE05;
                cfg_we    = 1'b1;
            end
            if (n == 101) cfg_we = 1'b0;
            n++;
            @(negedge clk);
        end
        chk(n == 1000, "R8 running length kept", n, 1000);
        chk(cfg_rdata[7:0] == 8'd5, "R8 stored", cfg_rdata[7:0], 5);
        pulse_src();
        hold_len(n);
        chk(n == 2500, "R8 next length", n, 2500);
    endtask

    task automatic t_restart();
        int n;
        wr(1, 1, 1, 1, 1);
        chk(cfg_rdata[8] == 1'b0, "R9 reads zero", cfg_rdata[8], 0);
        chk(cfg_rdata[12] == 1'b1, "R9 idle start", cfg_rdata[12], 1);
        hold_len(n);
        chk(n == 500, "R9 idle length", n, 500);
        wr(2, 0, 1, 1, 1);
        pulse_src();
        repeat (300) @(negedge clk);
        wr(2, 1, 1, 1, 1);
        hold_len(n);
        chk(n == 1000, "R9 restart length", n, 1000);
    endtask

    task automatic t_pme();
        wr(3, 0, 1, 1, 1);
        pulse_src();
        pme_irq = 1'b1;
        @(negedge clk);
        chk(irq_out == 1'b1, "R10 bypass", irq_out, 1);
        chk(cfg_rdata[12] == 1'b1, "R10 still holding", cfg_rdata[12], 1);
        pme_irq = 1'b0;
        @(negedge clk);
        chk(irq_out == 1'b0, "R10 released", irq_out, 0);
        wr(3, 0, 0, 1, 1);
        pme_irq = 1'b1;
        src_pending = 8'h80;
        @(negedge clk);
        chk(irq_out == 1'b0, "R2 pme disabled", irq_out, 0);
        chk(cfg_rdata[13] == 1'b1, "R2 status live", cfg_rdata[13], 1);
        pme_irq = 1'b0;
        src_pending = 8'h00;
        wr(0, 0, 1, 1, 1);
    endtask

    task automatic t_open_drain();
        wr(0, 0, 1, 1, 0);
        src_pending = 8'h01;
        @(negedge clk);
        chk(irq_out == 1'b0 && irq_oe == 1'b1, "R4 asserted", {irq_out, irq_oe}, 1);
        src_pending = 8'h00;
        @(negedge clk);
        chk(irq_out == 1'b0 && irq_oe == 1'b0, "R4 released", {irq_out, irq_oe}, 0);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_master();
        t_polarity();
        t_block();
        t_cancel();
        t_rewrite();
        t_restart();
        t_pme();
        t_open_drain();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule